// File: doc/BRIEF.md
# Vertical-Blank Synchronized Register Commit

This block is a double-buffer stage placed between a set of host-written holding registers and the active control values that feed a display channel's converters and gain stages. The host may rewrite the holding registers at any moment; those values stay invisible downstream until the next vertical blanking interval. At that point every register is copied into the active bank on the same clock edge. Picture settings therefore never change part-way through a frame, and different settings are never applied in different frames.

The stage watches a composite blanking input. It recognises a vertical blank by measuring how long each high pulse lasts. Pulses that stay high for at least a programmable number of clock cycles count as vertical blanks. Shorter pulses are horizontal blanks and are ignored. The default threshold corresponds to 300 µs at a 125 MHz clock. A commit is refused when the serial bus reports a transfer in progress on the qualifying cycle, so a partly written set of values is never applied. A bypass input turns off the synchronised path, and the active bank then tracks the holding bus on every cycle. A one-cycle strobe marks each synchronised load.

Top module: `vsync_commit`

## Requirements
- R1: While reset is high and on the first cycle after it, the active bus is all zeros and the strobe is low.
- R2: With bypass low, changes on the holding bus never reach the active bus unless a qualified vertical blank commits them.
- R3: A blank pulse that stays high for fewer than VB_MIN_CYCLES consecutive clock cycles causes no commit and no strobe.
- R4: When the blank input has been sampled high on VB_MIN_CYCLES consecutive rising edges, all registers are loaded at that last edge from the holding-bus value sampled there.
- R5: The strobe goes high for exactly one cycle, on the same edge as the synchronised load, and rises at most once per blank pulse, however long the pulse lasts.
- R6: If the busy input is high on the qualifying edge, no commit and no strobe happen for that pulse, and the active bus keeps its value.
- R7: A commit applies the newest holding-bus contents. Values that were overwritten before the blank are lost.
- R8: With bypass high, the active bus equals the holding bus sampled on the previous rising edge, and the strobe stays low, even during long blank pulses.
- R9: Holding-bus writes made after a commit but within the same blank pulse are held back until the next qualifying pulse.
- R10: Only the busy level on the qualifying edge matters. Busy that drops before that edge does not block the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_bus | input | NUM_REGS*REG_W | Holding registers, register i in bits [i*REG_W +: REG_W] |
| bus_busy | input | 1 | High while a serial bus write is in progress |
| blank_in | input | 1 | Composite blanking, active high |
| refresh_off | input | 1 | 1 = bypass the synchronised path, 0 = synchronised commit |
| active_bus | output | NUM_REGS*REG_W | Active control values, same layout as hold_bus |
| refresh_pulse | output | 1 | One-cycle strobe on each synchronised load |

## Verification
A wrong pulse-width count shows up as a commit one or more edges early or late, or as a commit on a short pulse. The bench therefore samples the active bus on the edge just before the qualifying edge and again on the qualifying edge itself. A re-arm fault in the qualifier appears as a second strobe inside one long pulse. It also appears as data written mid-pulse reaching the outputs early, which the bench sees within a few dozen cycles. Faults in the busy or bypass gating show up on the very next edge, as an active bus that moved or failed to move.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    // default vertical-blank qualifier: 300 us at 125 MHz
    localparam int unsigned SYS_CLK_MHZ       = 125;
    localparam int unsigned VB_MIN_US         = 300;
    localparam int unsigned VB_DEFAULT_CYCLES = SYS_CLK_MHZ * VB_MIN_US;

    typedef enum logic {
        MODE_SYNC = 1'b0,
        MODE_THRU = 1'b1
    } commit_mode_e;

    typedef struct packed {
        logic load;    // copy holding bus into active bank this edge
        logic strobe;  // this load came through the synchronised path
    } commit_t;

    function automatic commit_mode_e mode_of(input logic refresh_off);
        return refresh_off ? MODE_THRU : MODE_SYNC;
    endfunction

endpackage

// File: rtl/vsc_blank_meter.sv
module vsc_blank_meter #(
    parameter int unsigned MIN_CYC = vsc_pkg::VB_DEFAULT_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic blank_in,
    output logic vb_hit
);
    localparam int unsigned CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] SAT  = CW'(MIN_CYC);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

    logic [CW-1:0] run_len;

    // run length of consecutive high samples, saturating at the threshold
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (!blank_in) begin
            run_len <= '0;
        end else if (run_len != SAT) begin
            run_len <= run_len + 1'b1;
        end
    end

    // true on the edge that completes the MIN_CYC-th high sample
    assign vb_hit = blank_in && (run_len == LAST);

endmodule

// File: rtl/vsc_commit_ctrl.sv
module vsc_commit_ctrl
    import vsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    vb_hit,
    input  logic    bus_busy,
    input  logic    refresh_off,
    output commit_t ctl,
    output logic    refresh_pulse
);
    commit_mode_e mode;
    logic         sync_go;

    assign mode    = mode_of(refresh_off);
    assign sync_go = (mode == MODE_SYNC) && vb_hit && !bus_busy;

    always_comb begin
        ctl.strobe = sync_go;
        ctl.load   = sync_go || (mode == MODE_THRU);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            refresh_pulse <= 1'b0;
        end else begin
            refresh_pulse <= ctl.strobe;
        end
    end

endmodule

// File: rtl/vsc_active_bank.sv
module vsc_active_bank #(
    parameter int unsigned NUM_REGS = 11,
    parameter int unsigned REG_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [NUM_REGS*REG_W-1:0] hold_bus,
    output logic [NUM_REGS*REG_W-1:0] active_bus
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [REG_W-1:0] val;
        always_ff @(posedge clk) begin
            if (rst) begin
                val <= '0;
            end else if (load) begin
                val <= hold_bus[i*REG_W +: REG_W];
            end
        end
        assign active_bus[i*REG_W +: REG_W] = val;
    end

endmodule

// File: rtl/vsync_commit.sv
module vsync_commit
    import vsc_pkg::*;
#(
    parameter int unsigned NUM_REGS      = 11,
    parameter int unsigned REG_W         = 8,
    parameter int unsigned VB_MIN_CYCLES = VB_DEFAULT_CYCLES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_REGS*REG_W-1:0] hold_bus,
    input  logic                      bus_busy,
    input  logic                      blank_in,
    input  logic                      refresh_off,
    output logic [NUM_REGS*REG_W-1:0] active_bus,
    output logic                      refresh_pulse
);
    logic    vb_hit;
    commit_t ctl;

    vsc_blank_meter #(.MIN_CYC(VB_MIN_CYCLES)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .blank_in (blank_in),
        .vb_hit   (vb_hit)
    );

    vsc_commit_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .vb_hit        (vb_hit),
        .bus_busy      (bus_busy),
        .refresh_off   (refresh_off),
        .ctl           (ctl),
        .refresh_pulse (refresh_pulse)
    );

    vsc_active_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .load       (ctl.load),
        .hold_bus   (hold_bus),
        .active_bus (active_bus)
    );

endmodule

// File: rtl/vsc_checker.sv
module vsc_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] hold_bus,
    input logic         bus_busy,
    input logic         refresh_off,
    input logic [W-1:0] active_bus,
    input logic         refresh_pulse
);
    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_pulse |=> !refresh_pulse);

    // R4
    strobe_data_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_pulse |-> active_bus == $past(hold_bus));

    // R6
    strobe_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_pulse |-> !$past(bus_busy));

    // R2
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(refresh_off) && !refresh_pulse) |-> $stable(active_bus));

    // R8
    bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(refresh_off) && !$past(rst)) |-> active_bus == $past(hold_bus));

    // R8
    bypass_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $past(refresh_off) |-> !refresh_pulse);

endmodule

bind vsync_commit vsc_checker #(.W(NUM_REGS*REG_W)) u_vsc_checker (
    .clk           (clk),
    .rst           (rst),
    .hold_bus      (hold_bus),
    .bus_busy      (bus_busy),
    .refresh_off   (refresh_off),
    .active_bus    (active_bus),
    .refresh_pulse (refresh_pulse)
);

// File: tb/sim_vsync_commit.sv
module sim_vsync_commit;
    localparam int NR = 4;
    localparam int RW = 8;
    localparam int VB = 16;
    localparam int BW = NR * RW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [BW-1:0] hold_bus = '0;
    logic          bus_busy = 1'b0;
    logic          blank_in = 1'b0;
    logic          refresh_off = 1'b0;
    logic [BW-1:0] active_bus;
    logic          refresh_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int strobes = 0;
    logic [BW-1:0] exp_act = '0;

    always #4 clk = ~clk;  // 125 MHz

    vsync_commit #(.NUM_REGS(NR), .REG_W(RW), .VB_MIN_CYCLES(VB)) u0 (
        .clk           (clk),
        .rst           (rst),
        .hold_bus      (hold_bus),
        .bus_busy      (bus_busy),
        .blank_in      (blank_in),
        .refresh_off   (refresh_off),
        .active_bus    (active_bus),
        .refresh_pulse (refresh_pulse)
    );

    // strobe tally: reads the value from before the edge, so each pulse counts once
    always @(posedge clk) if (!rst && refresh_pulse) strobes++;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; blank sampled high on len rising edges
    task automatic blank_run(input int len);
        blank_in = 1'b1;
        idle(len);
        blank_in = 1'b0;
        idle(3);
    endtask

    task automatic t_reset;
        idle(3);
        check("R1 active in reset", 64'(active_bus), 64'(0));
        check("R1 strobe in reset", 64'(refresh_pulse), 64'(0));
        rst = 1'b0;
        idle(1);
        check("R1 active after reset", 64'(active_bus), 64'(0));
        check("R1 strobe after reset", 64'(refresh_pulse), 64'(0));
    endtask

    task automatic t_no_blank;
        hold_bus = 32'h1122_3344; idle(3);
        hold_bus = 32'h5566_7788; idle(3);
        check("R2 no blank keeps active", 64'(active_bus), 64'(exp_act));
    endtask

    task automatic t_commit_edge;
        int s0 = strobes;
        hold_bus = 32'hA1B2_C3D4;
        blank_in = 1'b1;
        idle(VB - 1);
        check("R4 no load before threshold", 64'(active_bus), 64'(exp_act));
        idle(1);
        exp_act = 32'hA1B2_C3D4;
        check("R4 load on threshold edge", 64'(active_bus), 64'(exp_act));
        check("R5 strobe with load", 64'(refresh_pulse), 64'(1));
        idle(1);
        check("R5 strobe one cycle", 64'(refresh_pulse), 64'(0));
        blank_in = 1'b0;
        idle(3);
        check("R5 one strobe counted", 64'(strobes - s0), 64'(1));
    endtask

    task automatic t_short;
        int s0 = strobes;
        hold_bus = 32'h0F0F_0F0F;
        blank_run(VB - 1);
        check("R3 short pulse no commit", 64'(active_bus), 64'(exp_act));
        check("R3 short pulse no strobe", 64'(strobes - s0), 64'(0));
    endtask

    task automatic t_long_pulse;
        int s0 = strobes;
        hold_bus = 32'hCAFE_0001;
        blank_in = 1'b1;
        idle(VB);
        exp_act = 32'hCAFE_0001;
        hold_bus = 32'hCAFE_0002;
        idle(30);
        blank_in = 1'b0;
        idle(3);
        check("R9 mid-pulse write held", 64'(active_bus), 64'(exp_act));
        check("R5 one strobe per long pulse", 64'(strobes - s0), 64'(1));
        blank_run(VB);
        exp_act = 32'hCAFE_0002;
        check("R9 next pulse applies write", 64'(active_bus), 64'(exp_act));
    endtask

    task automatic t_busy_skip;
        int s0 = strobes;
        hold_bus = 32'hBEEF_0055;
        bus_busy = 1'b1;
        blank_run(VB + 5);
        bus_busy = 1'b0;
        check("R6 busy blocks commit", 64'(active_bus), 64'(exp_act));
        check("R6 busy blocks strobe", 64'(strobes - s0), 64'(0));
        blank_run(VB);
        exp_act = 32'hBEEF_0055;
        check("R6 held data applied later", 64'(active_bus), 64'(exp_act));
    endtask

    task automatic t_busy_early;
        hold_bus = 32'h6666_7777;
        blank_in = 1'b1;
        bus_busy = 1'b1;
        idle(VB - 2);
        bus_busy = 1'b0;
        idle(2);
        blank_in = 1'b0;
        idle(3);
        exp_act = 32'h6666_7777;
        check("R10 early busy ignored", 64'(active_bus), 64'(exp_act));
    endtask

    task automatic t_latest;
        hold_bus = 32'h1111_1111; idle(3);
        hold_bus = 32'h2222_2222; idle(3);
        blank_run(VB);
        exp_act = 32'h2222_2222;
        check("R7 newest value committed", 64'(active_bus), 64'(exp_act));
    endtask

    task automatic t_bypass;
        int s0;
        refresh_off = 1'b1;
        hold_bus = 32'h9999_0000;
        idle(1);
        check("R8 bypass follows", 64'(active_bus), 64'(32'h9999_0000));
        hold_bus = 32'h9999_0001;
        idle(1);
        check("R8 bypass follows again", 64'(active_bus), 64'(32'h9999_0001));
        s0 = strobes;
        blank_run(VB + 2);
        check("R8 bypass no strobe", 64'(strobes - s0), 64'(0));
        refresh_off = 1'b0;
        exp_act = 32'h9999_0001;
        hold_bus = 32'h4444_5555;
        idle(2);
        check("R2 sync resumes holding", 64'(active_bus), 64'(exp_act));
    endtask

    initial begin
        idle(1);
        t_reset();
        t_no_blank();
        t_commit_edge();
        t_short();
        t_long_pulse();
        t_busy_skip();
        t_busy_early();
        t_latest();
        t_bypass();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule